// File: doc/BRIEF.md
# Backlight Start-up and Fault Sequencer

This block is the digital control core of a boost-converter LED backlight supply. When enabled, it first charges the output capacitor through a resistive path while the input isolation switch stays off. Once a comparator reports that the output is close enough to the input, it closes the isolation switch. It then enables converter switching and raises an 8-bit soft-start reference one step at a time until full scale.

Three protection events force a latched shutdown:
- the pre-charge phase runs out of time;
- the cycle over-current flag stays high for too long;
- the output falls below the input by the short-circuit margin.

A latched shutdown removes all drive and keeps the isolation switch open. Only the synchronous reset (the supply power-on reset) or taking enable low clears it. A supply-undervoltage flag also stops operation, but it does not latch. Every input passes through a two-flop synchroniser. All timing is counted on a 1 kHz tick strobe.

Top module: `bl_startup_seq`

## Requirements
- R1: After reset, and whenever enable is low, the outputs are in the off state: pre-charge 0, isolation gate drive 1, switching 0, reference code 0, done 0, fault 0.
- R2: With enable high and undervoltage low, the block enters pre-charge. In pre-charge, the pre-charge output is 1, the gate drive is 1 (switch off), switching is 0 and fault is 0.
- R3: When the pre-charge-complete flag is seen in pre-charge, the pre-charge output goes to 0, the gate drive goes to 0 and switching goes to 1. Switching is never 1 while the gate drive is 1.
- R4: After the isolation switch turns on, the reference code starts at 0 and rises by exactly 1 every STEP_TICKS ticks until it reaches 255, where it holds. The done output is 1 exactly when the code is 255.
- R5: If pre-charge-complete has not been seen by the 32nd tick counted in pre-charge, the block latches fault = 1 and the gate drive stays 1. After 31 ticks there is no fault.
- R6: The over-current flag held high through 17 consecutive ticks while switching latches fault. After 16 such ticks there is no fault. If the flag drops before expiry, the count restarts from zero.
- R7: The short-circuit flag seen while switching latches fault at once, with the gate drive at 1 and switching at 0.
- R8: A latched fault holds fault = 1 with all drive off, whatever the other inputs do, while enable stays high. Taking enable low clears it to the off state. Taking enable high again restarts pre-charge.
- R9: Enable going low from any active state returns all outputs to the off state without setting fault.
- R10: The undervoltage flag high stops the block and gives the off state with fault = 0. When the flag is released with enable still high, the block restarts from pre-charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (supply power-on reset) |
| en_i | input | 1 | Enable request |
| uv_i | input | 1 | Supply undervoltage flag (hysteresis applied upstream) |
| pc_ok_i | input | 1 | Output within pre-charge threshold of input |
| short_i | input | 1 | Output below input by the short margin |
| oc_i | input | 1 | Cycle-by-cycle over-current flag |
| tick_i | input | 1 | 1 kHz strobe, one clock wide |
| prechg_o | output | 1 | Connect pre-charge resistor |
| iso_gate_n_o | output | 1 | Isolation switch gate drive, 0 = switch on |
| sw_en_o | output | 1 | Converter switching enable |
| ref_code_o | output | 8 | Soft-start reference code |
| ref_done_o | output | 1 | Reference at full scale |
| fault_o | output | 1 | Latched shutdown status |

## Verification
The hardest cases to reach are the exact timer boundaries. The block must not trip on the 31st pre-charge tick or the 16th over-current tick, and it must trip on the next one. Each input first crosses a two-flop synchroniser, and the tick is only counted in certain states. To reach these boundaries, the bench owns the tick strobe and spaces each pulse so that it lands in a known state. It then runs directed boundary cases plus seeded random episodes. Each random episode picks a pre-charge delay and an over-current duration on either side of the limits, and a bench function predicts the outcome.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int REF_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRECHG = 3'd1,
        ST_SOFT   = 3'd2,
        ST_RUN    = 3'd3,
        ST_LATCH  = 3'd4
    } bl_state_e;

    typedef struct packed {
        logic en;
        logic uv;
        logic pc_ok;
        logic shrt;
        logic oc;
        logic tick;
    } bl_in_t;

    localparam int IN_W = $bits(bl_in_t);

    function automatic logic is_switching(bl_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/bl_ms_timer.sv
module bl_ms_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CW'(LIMIT - 1))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: an idle timer restarts from zero
    p_timer_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/bl_ramp.sv
module bl_ramp #(
    parameter int W    = 8,
    parameter int STEP = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active_i,
    input  logic         tick_i,
    output logic [W-1:0] code_o,
    output logic         done_o
);
    localparam int          SW   = $clog2(STEP + 1);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [SW-1:0] sub_q;

    assign done_o = (code_o == FULL);

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            sub_q  <= '0;
            code_o <= '0;
        end else if (tick_i && (code_o != FULL)) begin
            if (sub_q == SW'(STEP - 1)) begin
                sub_q  <= '0;
                code_o <= code_o + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // R4: code moves by at most one step per clock while active
    p_ramp_step_r4: assert property (@(posedge clk) disable iff (rst)
        active_i |=> (code_o == $past(code_o)) || (code_o == $past(code_o) + 1'b1));
endmodule

// File: rtl/bl_startup_seq.sv
module bl_startup_seq
    import bl_pkg::*;
#(
    parameter int PC_TIMEOUT_MS = 32,
    parameter int OC_HOLD_MS    = 16,
    parameter int STEP_TICKS    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             uv_i,
    input  logic             pc_ok_i,
    input  logic             short_i,
    input  logic             oc_i,
    input  logic             tick_i,
    output logic             prechg_o,
    output logic             iso_gate_n_o,
    output logic             sw_en_o,
    output logic [REF_W-1:0] ref_code_o,
    output logic             ref_done_o,
    output logic             fault_o
);
    localparam int OC_TRIP = OC_HOLD_MS + 1;

    bl_in_t    in_s;
    logic [IN_W-1:0] sync_q;
    bl_state_e state_q, state_d;
    logic      pc_exp, oc_exp, ramp_done;

    bl_sync #(.W(IN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({en_i, uv_i, pc_ok_i, short_i, oc_i, tick_i}),
        .q_o (sync_q)
    );
    assign in_s = sync_q;

    bl_ms_timer #(.LIMIT(PC_TIMEOUT_MS)) u_pc_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (state_q == ST_PRECHG),
        .tick_i   (in_s.tick),
        .expire_o (pc_exp)
    );

    bl_ms_timer #(.LIMIT(OC_TRIP)) u_oc_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (in_s.oc && is_switching(state_q)),
        .tick_i   (in_s.tick),
        .expire_o (oc_exp)
    );

    bl_ramp #(.W(REF_W), .STEP(STEP_TICKS)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .active_i (is_switching(state_q)),
        .tick_i   (in_s.tick),
        .code_o   (ref_code_o),
        .done_o   (ramp_done)
    );

    always_comb begin
        state_d = state_q;
        if (!in_s.en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (!in_s.uv) state_d = ST_PRECHG;
                ST_PRECHG: begin
                    if (in_s.uv)         state_d = ST_IDLE;
                    else if (in_s.pc_ok) state_d = ST_SOFT;
                    else if (pc_exp)     state_d = ST_LATCH;
                end
                ST_SOFT, ST_RUN: begin
                    if (in_s.uv)        state_d = ST_IDLE;
                    else if (in_s.shrt) state_d = ST_LATCH;
                    else if (oc_exp)    state_d = ST_LATCH;
                    else if (state_q == ST_SOFT && ramp_done) state_d = ST_RUN;
                end
                ST_LATCH:  state_d = ST_LATCH;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign prechg_o     = (state_q == ST_PRECHG);
    assign sw_en_o      = is_switching(state_q);
    assign iso_gate_n_o = !is_switching(state_q);
    assign fault_o      = (state_q == ST_LATCH);
    assign ref_done_o   = ramp_done;

    // R3: switching only with the isolation switch closed
    p_sw_needs_iso_r3: assert property (@(posedge clk) disable iff (rst)
        sw_en_o |-> !iso_gate_n_o);
    // R2: pre-charge path never overlaps a closed isolation switch
    p_prechg_iso_off_r2: assert property (@(posedge clk) disable iff (rst)
        prechg_o |-> iso_gate_n_o);
    // R7: short while switching latches on the next clock
    p_short_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_en_o && in_s.shrt && in_s.en && !in_s.uv) |=> fault_o);
    // R8: fault holds while enable stays high
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_o && in_s.en) |=> fault_o);
    // R9: enable low always gives the off state next
    p_en_off_r9: assert property (@(posedge clk) disable iff (rst)
        !in_s.en |=> (!sw_en_o && !prechg_o && !fault_o));
endmodule

// File: tb/test_bl_startup_seq.sv
module test_bl_startup_seq;
    logic clk = 0, rst = 1;
    logic en = 0, uv = 0, pc_ok = 0, shrt = 0, oc = 0, tick = 0;
    logic prechg, gate_n, sw_en, done, fault;
    logic [7:0] code;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    bl_startup_seq i_bl_startup_seq (
        .clk(clk), .rst(rst), .en_i(en), .uv_i(uv), .pc_ok_i(pc_ok),
        .short_i(shrt), .oc_i(oc), .tick_i(tick),
        .prechg_o(prechg), .iso_gate_n_o(gate_n), .sw_en_o(sw_en),
        .ref_code_o(code), .ref_done_o(done), .fault_o(fault)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pack outputs as {prechg,gate_n,sw_en,fault}
    function automatic int outs();
        return {prechg, gate_n, sw_en, fault};
    endfunction
    function automatic int exp_precharge_fault(int n_ticks);
        return (n_ticks >= 32) ? 1 : 0;
    endfunction
    function automatic int exp_oc_fault(int n_ticks);
        return (n_ticks >= 17) ? 1 : 0;
    endfunction

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1;
            @(negedge clk) tick = 0;
            wait_clk(3);
        end
    endtask
    task automatic restart();
        en = 0; pc_ok = 0; shrt = 0; oc = 0; uv = 0;
        wait_clk(5);
        en = 1;
        wait_clk(5);
    endtask

    localparam int OFF  = 4'b0100;
    localparam int PREC = 4'b1100;
    localparam int SW   = 4'b0010;
    localparam int LAT  = 4'b0101;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog expired");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        wait_clk(4);
        rst = 0;
        wait_clk(2);
        check("R1 reset outputs", outs(), OFF);
        check("R1 reset code", code, 0);
        wait_clk(10);
        check("R1 idle while enable low", outs(), OFF);

        en = 1; wait_clk(5);
        check("R2 precharge entry", outs(), PREC);
        pc_ok = 1; wait_clk(5);
        check("R3 iso on and switching", outs(), SW);
        check("R4 code starts at 0", code, 0);
        pulse_ticks(2);
        check("R4 code after one step", code, 1);
        pulse_ticks(1);
        check("R4 code holds between steps", code, 1);
        pulse_ticks(505);
        check("R4 code at 254", code, 254);
        check("R4 done low below full", done, 0);
        pulse_ticks(2);
        check("R4 code full scale", code, 255);
        check("R4 done at full", done, 1);
        pulse_ticks(4);
        check("R4 code saturates", code, 255);

        // R6 boundary in run
        oc = 1; wait_clk(4);
        pulse_ticks(16);
        check("R6 no trip after 16 ticks", fault, 0);
        oc = 0; wait_clk(4); oc = 1; wait_clk(4);
        pulse_ticks(16);
        check("R6 count restarts after drop", fault, 0);
        pulse_ticks(1);
        check("R6 trip on 17th tick", outs(), LAT);
        oc = 0; pc_ok = 0; wait_clk(4);
        pulse_ticks(3);
        check("R8 latch holds", outs(), LAT);
        en = 0; wait_clk(5);
        check("R8 enable low clears latch", outs(), OFF);
        en = 1; wait_clk(5);
        check("R8 enable high restarts precharge", outs(), PREC);

        // R5 boundary
        pulse_ticks(31);
        check("R5 no timeout at 31 ticks", outs(), PREC);
        pulse_ticks(1);
        check("R5 timeout latches", outs(), LAT);
        pc_ok = 1; wait_clk(5);
        check("R8 latch ignores precharge ok", outs(), LAT);

        // R7 short
        restart(); pc_ok = 1; wait_clk(5);
        check("R3 switching again", outs(), SW);
        shrt = 1; wait_clk(4);
        check("R7 short latches", outs(), LAT);
        shrt = 0; wait_clk(5);
        check("R8 latch after short clears", outs(), LAT);

        // R9 enable low while switching
        restart(); pc_ok = 1; wait_clk(5);
        pulse_ticks(4);
        en = 0; wait_clk(4);
        check("R9 enable low shuts off", outs(), OFF);
        check("R9 code cleared", code, 0);

        // R10 undervoltage
        restart(); pc_ok = 1; wait_clk(5);
        uv = 1; wait_clk(4);
        check("R10 undervoltage off", outs(), OFF);
        pc_ok = 0; uv = 0; wait_clk(5);
        check("R10 restart after release", outs(), PREC);

        // random episodes
        for (int ep = 0; ep < 20; ep++) begin
            int np, no, ef;
            restart();
            np = $urandom_range(40, 20);
            pulse_ticks(np);
            ef = exp_precharge_fault(np);
            check("R5 random precharge delay", fault, ef);
            if (ef == 0) begin
                pc_ok = 1; wait_clk(5);
                no = $urandom_range(20, 12);
                oc = 1; wait_clk(4);
                pulse_ticks(no);
                check("R6 random over-current hold", fault, exp_oc_fault(no));
                check("R3 random gate vs fault", gate_n, exp_oc_fault(no));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule